// File: doc/BRIEF.md
# Exception Activation Mask Gate

This block decides which pending exception may be activated next. It receives a vector of configurable-priority requests, each with a priority value, and one fixed non-maskable request. Three software-writable mask registers are held inside it: a one-bit block-all-configurable flag, a one-bit block-everything-but-the-non-maskable flag, and a priority threshold. Requests that survive all three masks, and that would preempt the currently running handler, go through winner selection. The result is a registered activation request carrying the winning index and its priority.

A smaller priority value means greater urgency. The threshold blocks a request whose value is greater than or equal to the threshold, but only while the threshold is nonzero. When a handler returns, the fault-style flag clears itself, unless the returning handler is the non-maskable one. Stacking, vector fetch and instruction decode sit elsewhere. This block only arbitrates admission.

Top module: `excg_gate`

## Requirements
- R1: While `rst` is high, and in the cycle after it falls, all three mask registers hold zero, `act_valid`/`act_nmi` are 0 and `act_idx`, `act_prio` and `rd_data` are zero.
- R2: While the priority-mask flag (selector 0, bit 0) is 1, no configurable request is activated. The non-maskable request is unaffected.
- R3: While the fault-mask flag (selector 1, bit 0) is 1, no configurable request is activated. The non-maskable request is unaffected.
- R4: While the threshold (selector 2, bits PRIO_W-1:0) is nonzero, a configurable request whose priority value is greater than or equal to it is not activated. A threshold of zero blocks nothing.
- R5: Among the eligible requests, the winner is the non-maskable request if it is eligible, reported with `act_idx` = NUM_IRQ, `act_nmi` = 1 and `act_prio` = 0. Otherwise the winner is the configurable request with the smallest priority value, and a tie goes to the lowest index.
- R6: When `run_active` is 1, a configurable request is eligible only if its priority is strictly smaller than `run_prio`. When `run_active` and `run_nmi` are both 1, nothing is eligible, not even the non-maskable request.
- R7: A high `exc_ret` clears the fault-mask flag at the next edge unless `run_nmi` is 1. This clear overrides a software write of 1 to that flag in the same cycle.
- R8: A register write changes masking from the following cycle onward. Activation outputs reflect the inputs and the mask state of the previous clock edge (one register stage).
- R9: `rd_data` returns the register chosen by `rd_sel` one cycle later, with bits 31:1 (flags) or 31:PRIO_W (threshold) reading zero. Selector 3 reads zero, and writes to it change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_pend | input | NUM_IRQ | Pending configurable requests, bit i = index i |
| req_prio | input | NUM_IRQ*PRIO_W | Priority of request i in bits i*PRIO_W +: PRIO_W |
| nmi_pend | input | 1 | Pending non-maskable request |
| run_active | input | 1 | A handler is currently running |
| run_nmi | input | 1 | The running handler is the non-maskable one |
| run_prio | input | PRIO_W | Priority of the running handler |
| exc_ret | input | 1 | Handler return strobe |
| wr_en | input | 1 | Mask register write strobe |
| wr_sel | input | 2 | Write target: 0 priority mask, 1 fault mask, 2 threshold, 3 none |
| wr_data | input | 32 | Write data |
| rd_sel | input | 2 | Read selector, same encoding as `wr_sel` |
| rd_data | output | 32 | Registered read data |
| act_valid | output | 1 | Activation request |
| act_nmi | output | 1 | Winner is the non-maskable request |
| act_idx | output | IDX_W | Winning index (NUM_IRQ for non-maskable) |
| act_prio | output | PRIO_W | Winning priority (0 for non-maskable) |

## Verification
The bench builds the gate with NUM_IRQ = 5 and PRIO_W = 3. With only eight priority values, random stimulus often produces equal priorities, which exercises the lowest-index tie-break. Requests also land exactly on the threshold and exactly on the running priority, so both boundary comparisons are covered. With five requests, directed phases can hold all requests pending and still reach every index as winner. The small threshold range also lets threshold zero and threshold equal to the top value both occur many times.

// File: rtl/excg_pkg.sv
package excg_pkg;

  // Mask register selector; the encoding is visible on wr_sel / rd_sel.
  typedef enum logic [1:0] {
    SEL_PRIM  = 2'd0,
    SEL_FAULT = 2'd1,
    SEL_BASE  = 2'd2,
    SEL_NONE  = 2'd3
  } mreg_sel_e;

  localparam int unsigned BUS_W = 32;

endpackage

// File: rtl/excg_mask_regs.sv
module excg_mask_regs
  import excg_pkg::*;
#(
  parameter int unsigned PRIO_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [PRIO_W-1:0] wr_val,
  input  logic              exc_ret,
  input  logic              ret_nmi,
  input  logic [1:0]        rd_sel,
  output logic              pm_q,
  output logic              fm_q,
  output logic [PRIO_W-1:0] bp_q,
  output logic [BUS_W-1:0]  rd_data
);

  mreg_sel_e wsel, rsel;
  logic      ret_clear;
  logic [BUS_W-1:0] rd_next;

  assign wsel      = mreg_sel_e'(wr_sel);
  assign rsel      = mreg_sel_e'(rd_sel);
  assign ret_clear = exc_ret && !ret_nmi;

  always_ff @(posedge clk) begin
    if (rst) begin
      pm_q <= 1'b0;
    end else if (wr_en && wsel == SEL_PRIM) begin
      pm_q <= wr_val[0];
    end
  end

  // Return-driven clear outranks a same-cycle software write.
  always_ff @(posedge clk) begin
    if (rst) begin
      fm_q <= 1'b0;
    end else if (ret_clear) begin
      fm_q <= 1'b0;
    end else if (wr_en && wsel == SEL_FAULT) begin
      fm_q <= wr_val[0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bp_q <= '0;
    end else if (wr_en && wsel == SEL_BASE) begin
      bp_q <= wr_val;
    end
  end

  always_comb begin
    rd_next = '0;
    unique case (rsel)
      SEL_PRIM:  rd_next[0] = pm_q;
      SEL_FAULT: rd_next[0] = fm_q;
      SEL_BASE:  rd_next[PRIO_W-1:0] = bp_q;
      default:   rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= rd_next;
  end

endmodule

// File: rtl/excg_filter.sv
module excg_filter #(
  parameter int unsigned NUM_IRQ = 8,
  parameter int unsigned PRIO_W  = 8
) (
  input  logic [NUM_IRQ-1:0]        req_pend,
  input  logic [NUM_IRQ*PRIO_W-1:0] req_prio,
  input  logic                      pm_q,
  input  logic                      fm_q,
  input  logic [PRIO_W-1:0]         bp_q,
  input  logic                      run_active,
  input  logic                      run_nmi,
  input  logic [PRIO_W-1:0]         run_prio,
  output logic [NUM_IRQ-1:0]        elig
);

  logic global_block;
  logic bp_on;

  assign global_block = pm_q || fm_q || (run_active && run_nmi);
  assign bp_on        = (bp_q != '0);

  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_req
    logic [PRIO_W-1:0] p;
    logic thr_ok, pre_ok;
    assign p      = req_prio[i*PRIO_W +: PRIO_W];
    assign thr_ok = !bp_on || (p < bp_q);
    assign pre_ok = !run_active || (p < run_prio);
    assign elig[i] = req_pend[i] && !global_block && thr_ok && pre_ok;
  end

endmodule

// File: rtl/excg_arbiter.sv
module excg_arbiter #(
  parameter int unsigned NUM_IRQ = 8,
  parameter int unsigned PRIO_W  = 8,
  localparam int unsigned IDX_W  = $clog2(NUM_IRQ + 1)
) (
  input  logic [NUM_IRQ-1:0]        elig,
  input  logic [NUM_IRQ*PRIO_W-1:0] req_prio,
  output logic                      any,
  output logic [IDX_W-1:0]          win_idx,
  output logic [PRIO_W-1:0]         win_prio
);

  // Strict less-than keeps the first (lowest) index on equal priorities.
  always_comb begin
    any      = 1'b0;
    win_idx  = '0;
    win_prio = '0;
    for (int i = 0; i < NUM_IRQ; i++) begin
      if (elig[i] && (!any || req_prio[i*PRIO_W +: PRIO_W] < win_prio)) begin
        any      = 1'b1;
        win_idx  = IDX_W'(i);
        win_prio = req_prio[i*PRIO_W +: PRIO_W];
      end
    end
  end

endmodule

// File: rtl/excg_gate.sv
module excg_gate
  import excg_pkg::*;
#(
  parameter int unsigned NUM_IRQ = 8,
  parameter int unsigned PRIO_W  = 8,
  localparam int unsigned IDX_W  = $clog2(NUM_IRQ + 1)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [NUM_IRQ-1:0]        req_pend,
  input  logic [NUM_IRQ*PRIO_W-1:0] req_prio,
  input  logic                      nmi_pend,
  input  logic                      run_active,
  input  logic                      run_nmi,
  input  logic [PRIO_W-1:0]         run_prio,
  input  logic                      exc_ret,
  input  logic                      wr_en,
  input  logic [1:0]                wr_sel,
  input  logic [31:0]               wr_data,
  input  logic [1:0]                rd_sel,
  output logic [31:0]               rd_data,
  output logic                      act_valid,
  output logic                      act_nmi,
  output logic [IDX_W-1:0]          act_idx,
  output logic [PRIO_W-1:0]         act_prio
);

  localparam logic [IDX_W-1:0] NMI_IDX = IDX_W'(NUM_IRQ);

  logic              pm_q, fm_q;
  logic [PRIO_W-1:0] bp_q;
  logic [NUM_IRQ-1:0] elig;
  logic              cfg_any;
  logic [IDX_W-1:0]  cfg_idx;
  logic [PRIO_W-1:0] cfg_prio;
  logic              nmi_ok;
  logic              unused_wr_hi;

  assign unused_wr_hi = ^wr_data[31:PRIO_W];

  excg_mask_regs #(.PRIO_W(PRIO_W)) u_regs (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_sel  (wr_sel),
    .wr_val  (wr_data[PRIO_W-1:0]),
    .exc_ret (exc_ret),
    .ret_nmi (run_nmi),
    .rd_sel  (rd_sel),
    .pm_q    (pm_q),
    .fm_q    (fm_q),
    .bp_q    (bp_q),
    .rd_data (rd_data)
  );

  excg_filter #(.NUM_IRQ(NUM_IRQ), .PRIO_W(PRIO_W)) u_filt (
    .req_pend   (req_pend),
    .req_prio   (req_prio),
    .pm_q       (pm_q),
    .fm_q       (fm_q),
    .bp_q       (bp_q),
    .run_active (run_active),
    .run_nmi    (run_nmi),
    .run_prio   (run_prio),
    .elig       (elig)
  );

  excg_arbiter #(.NUM_IRQ(NUM_IRQ), .PRIO_W(PRIO_W)) u_arb (
    .elig     (elig),
    .req_prio (req_prio),
    .any      (cfg_any),
    .win_idx  (cfg_idx),
    .win_prio (cfg_prio)
  );

  // The non-maskable request ignores all three masks; only a running
  // non-maskable handler holds it off.
  assign nmi_ok = nmi_pend && !(run_active && run_nmi);

  always_ff @(posedge clk) begin
    if (rst) begin
      act_valid <= 1'b0;
      act_nmi   <= 1'b0;
      act_idx   <= '0;
      act_prio  <= '0;
    end else if (nmi_ok) begin
      act_valid <= 1'b1;
      act_nmi   <= 1'b1;
      act_idx   <= NMI_IDX;
      act_prio  <= '0;
    end else begin
      act_valid <= cfg_any;
      act_nmi   <= 1'b0;
      act_idx   <= cfg_any ? cfg_idx  : '0;
      act_prio  <= cfg_any ? cfg_prio : '0;
    end
  end

endmodule

// File: rtl/excg_gate_chk.sv
module excg_gate_chk #(
  parameter int unsigned NUM_IRQ = 8,
  parameter int unsigned PRIO_W  = 8,
  localparam int unsigned IDX_W  = $clog2(NUM_IRQ + 1)
) (
  input logic              clk,
  input logic              rst,
  input logic              nmi_pend,
  input logic              run_active,
  input logic              run_nmi,
  input logic [PRIO_W-1:0] run_prio,
  input logic              exc_ret,
  input logic [31:0]       rd_data,
  input logic              act_valid,
  input logic              act_nmi,
  input logic [IDX_W-1:0]  act_idx,
  input logic [PRIO_W-1:0] act_prio,
  input logic              pm_q,
  input logic              fm_q,
  input logic [PRIO_W-1:0] bp_q
);

  assert_reset_idle_R1: assert property (@(posedge clk)
    rst |=> (!act_valid && !pm_q && !fm_q && bp_q == '0));

  assert_prim_blocks_R2: assert property (@(posedge clk) disable iff (rst)
    ($past(pm_q) && act_valid) |-> act_nmi);

  assert_fault_blocks_R3: assert property (@(posedge clk) disable iff (rst)
    ($past(fm_q) && act_valid) |-> act_nmi);

  assert_threshold_R4: assert property (@(posedge clk) disable iff (rst)
    (act_valid && !act_nmi && $past(bp_q) != '0) |-> (act_prio < $past(bp_q)));

  assert_nmi_wins_R5: assert property (@(posedge clk) disable iff (rst)
    (nmi_pend && !(run_active && run_nmi)) |=> (act_valid && act_nmi && act_idx == IDX_W'(NUM_IRQ)));

  assert_preempt_R6: assert property (@(posedge clk) disable iff (rst)
    (run_active && run_nmi) |=> !act_valid);

  assert_preempt_prio_R6: assert property (@(posedge clk) disable iff (rst)
    (act_valid && !act_nmi && $past(run_active)) |-> (act_prio < $past(run_prio)));

  assert_ret_clears_R7: assert property (@(posedge clk) disable iff (rst)
    (exc_ret && !run_nmi) |=> !fm_q);

  assert_reserved_zero_R9: assert property (@(posedge clk) disable iff (rst)
    (rd_data >> PRIO_W) == 32'd0);

endmodule

bind excg_gate excg_gate_chk #(.NUM_IRQ(NUM_IRQ), .PRIO_W(PRIO_W)) u_chk (.*);

// File: tb/sim_excg_gate.sv
`timescale 1ns/1ps
module sim_excg_gate;
  localparam int NI = 5;
  localparam int PW = 3;
  localparam int IW = $clog2(NI + 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NI-1:0] req_pend = '0;
  logic [NI*PW-1:0] req_prio = '0;
  logic nmi_pend = 0, run_active = 0, run_nmi = 0, exc_ret = 0, wr_en = 0;
  logic [PW-1:0] run_prio = '0;
  logic [1:0] wr_sel = '0, rd_sel = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic act_valid, act_nmi;
  logic [IW-1:0] act_idx;
  logic [PW-1:0] act_prio;

  always #2 clk = ~clk;  // 250 MHz

  excg_gate #(.NUM_IRQ(NI), .PRIO_W(PW)) u0 (.*);

  int vecs = 0, fails = 0, cyc = 0;
  bit started = 0;
  string tag = "R1";
  int m_pm = 0, m_fm = 0, m_bp = 0;
  int e_v = 0, e_n = 0, e_i = 0, e_p = 0, e_rd = 0;

  // Behavioural reference, evaluated on every rising edge.
  always @(posedge clk) begin
    int best, bi, p;
    cyc++;
    started = 1;
    if (rst) begin
      m_pm = 0; m_fm = 0; m_bp = 0;
      e_v = 0; e_n = 0; e_i = 0; e_p = 0; e_rd = 0;
    end else begin
      case (rd_sel)
        2'd0: e_rd = m_pm;
        2'd1: e_rd = m_fm;
        2'd2: e_rd = m_bp;
        default: e_rd = 0;
      endcase
      best = 1000; bi = -1;
      if (!(run_active && run_nmi) && !m_pm && !m_fm)
        for (int i = 0; i < NI; i++) begin
          p = int'(req_prio[i*PW +: PW]);
          if (req_pend[i] && (m_bp == 0 || p < m_bp) &&
              (!run_active || p < int'(run_prio)) && p < best) begin
            best = p; bi = i;
          end
        end
      if (nmi_pend && !(run_active && run_nmi)) begin
        e_v = 1; e_n = 1; e_i = NI; e_p = 0;
      end else if (bi >= 0) begin
        e_v = 1; e_n = 0; e_i = bi; e_p = best;
      end else begin
        e_v = 0; e_n = 0; e_i = 0; e_p = 0;
      end
      if (wr_en && wr_sel == 2'd0) m_pm = int'(wr_data[0]);
      if (wr_en && wr_sel == 2'd1) m_fm = int'(wr_data[0]);
      if (wr_en && wr_sel == 2'd2) m_bp = int'(wr_data[PW-1:0]);
      if (exc_ret && !run_nmi) m_fm = 0;
    end
    if (cyc > 60000) begin
      fails++;
      $display("FAIL R8 watchdog expired: actual %0d cycles, expected < 60000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
      $finish;
    end
  end

  task automatic chk(input string t, input string f, input int act, input int exp);
    vecs++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", t, f, act, exp, cyc);
    end
  endtask

  always @(negedge clk) if (started) begin
    chk(tag, "act_valid", int'(act_valid), e_v);
    chk(tag, "act_nmi",   int'(act_nmi),   e_n);
    chk(tag, "act_idx",   int'(act_idx),   e_i);
    chk(tag, "act_prio",  int'(act_prio),  e_p);
    chk(rst ? "R1" : "R9", "rd_data", int'(rd_data), e_rd);
  end

  // One random cycle; knobs bias the stimulus toward a requirement.
  task automatic step(input int nmi_pct, input int run_pct, input int ret_pct, input int wr_pct);
    @(negedge clk);
    #1;
    req_pend   = NI'($urandom);
    req_prio   = (NI*PW)'({$urandom, $urandom});
    nmi_pend   = ($urandom % 100) < nmi_pct;
    run_active = ($urandom % 100) < run_pct;
    run_nmi    = run_active && (($urandom % 4) == 0);
    run_prio   = PW'($urandom);
    exc_ret    = ($urandom % 100) < ret_pct;
    wr_en      = ($urandom % 100) < wr_pct;
    wr_sel     = 2'($urandom);
    wr_data    = $urandom;
    rd_sel     = 2'($urandom);
  endtask

  task automatic wreg(input int sel, input int val);
    @(negedge clk);
    #1;
    req_pend = '0; nmi_pend = 0; exc_ret = 0; run_active = 0;
    wr_en = 1; wr_sel = 2'(sel); wr_data = 32'(val) | 32'hFFFF_FFF0 & ~32'(2**PW - 1) | 32'(val);
    rd_sel = 2'(sel);
    @(negedge clk);
    #1;
    wr_en = 0;
  endtask

  task automatic hold_steps(input int n, input int nmi_pct, input int run_pct);
    for (int k = 0; k < n; k++) begin
      step(nmi_pct, run_pct, 0, 0);
      wr_en = 0; exc_ret = 0;
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); #1; rst = 0;
    tag = "R1"; hold_steps(1, 0, 0);
    // R2: priority-mask flag held, with upper bits of write data set
    tag = "R2"; wreg(0, 1); hold_steps(200, 20, 30); wreg(0, 0);
    // R3: fault-mask flag held
    tag = "R3"; wreg(1, 1); hold_steps(200, 20, 0); wreg(1, 0);
    // R4: threshold at every value including zero and the top value
    tag = "R4";
    for (int b = 0; b < (1 << PW); b++) begin
      wreg(2, b); hold_steps(40, 0, 0);
    end
    wreg(2, 0);
    // R5: no masks, no running handler, ties are frequent
    tag = "R5"; hold_steps(300, 15, 0);
    // R6: running handler of random priority, sometimes the non-maskable one
    tag = "R6"; hold_steps(300, 20, 100);
    // R7: fault mask set, returns with and without run_nmi, colliding writes
    tag = "R7";
    for (int k = 0; k < 200; k++) begin
      wreg(1, 1);
      step(0, 50, 60, 0);
      wr_en = ($urandom % 2) == 1; wr_sel = 2'd1; wr_data = 32'd1; rd_sel = 2'd1;
      @(negedge clk); #1; wr_en = 0; exc_ret = 0;
    end
    // R8: writes mixed into live traffic every cycle
    tag = "R8"; for (int k = 0; k < 600; k++) step(10, 40, 10, 40);
    // R9: reads of all selectors, writes to selector 3
    tag = "R9";
    for (int k = 0; k < 200; k++) begin
      step(0, 0, 0, 50);
      rd_sel = 2'($urandom);
    end
    wr_en = 0; exc_ret = 0;
    @(negedge clk); #1; rst = 1; tag = "R1";
    repeat (3) @(negedge clk);
    #1; rst = 0;
    repeat (2) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end

endmodule